// File: doc/BRIEF.md
# Calorimeter Trigger Tower Preprocessor

This block turns raw digitized calorimeter samples into one calibrated transverse-energy value per bunch crossing. Four tower channels each deliver a fresh 10-bit sample on every clock, and one clock is one 25 ns crossing. Each channel first goes through its own programmable delay so that all four towers line up in time. A three-sample window then finds the crossing that holds the pulse maximum. Only that crossing's sample is passed through a shared 1024-entry calibration table, which gives an 8-bit energy. Every other crossing contributes zero.

The four per-tower energies are added into one 2x2 jet element. The sum saturates when any tower reports full scale, and it also saturates if the total would overflow. Three sets of signals configure the block: the per-channel delays, one noise threshold, and the table contents. Each is written through a simple strobe, select and value group. The path from input sample to summed output has a fixed depth. That depth is published as a package constant, so the trigger logic downstream can compensate for it.

Top module: `tpp_tower_pre`

## Requirements
- R1: While reset is asserted and after it is released, `jet_et` reads 0. Every channel delay and the threshold come out of reset at 0.
- R2: Writing `dly_val` (0 to 7) for the channel selected by `dly_ch` with `dly_wr` high delays that channel's contribution to `jet_et` by exactly `dly_val` extra clocks. Other channels are not affected.
- R3: An aligned sample s[n] is a peak when s[n-1] < s[n] and s[n] >= s[n+1]. On a flat top, only the first sample of the plateau counts as a peak. Two adjacent crossings are never both peaks.
- R4: A peak is accepted only when s[n] is strictly greater than the threshold loaded through `thr_wr`/`thr_val`. A peak equal to the threshold gives no energy.
- R5: The energy of an accepted peak is the table entry addressed by the 10-bit peak sample. Writing `tbl_data` to address `tbl_addr` with `tbl_wr` high replaces that entry.
- R6: A tower contributes 0 on every crossing that is not an accepted peak.
- R7: `jet_et` is the sum of the four tower energies that belong to the same aligned crossing.
- R8: If any tower energy equals 0xFF, `jet_et` is 0x3FF. A sum above 0x3FF is also clamped to 0x3FF. A sum of four 0xFE energies (0x3F8) passes through unchanged.
- R9: With a delay of 0, the energy of sample n driven in cycle n appears on `jet_et` in cycle n+5. The package constant `TPP_BASE_LAT` holds this value, 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one sample per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_in | input | 40 | Four 10-bit samples, channel i at bits [10i+9:10i] |
| dly_wr | input | 1 | Strobe that loads a channel delay |
| dly_ch | input | 2 | Channel selected for the delay write |
| dly_val | input | 3 | Delay value, 0 to 7 clocks |
| thr_wr | input | 1 | Strobe that loads the threshold |
| thr_val | input | 10 | Threshold a peak must strictly exceed |
| tbl_wr | input | 1 | Strobe that writes the calibration table |
| tbl_addr | input | 10 | Table address (sample value) |
| tbl_data | input | 8 | Energy stored at that address |
| jet_et | output | 10 | Saturated 2x2 jet element energy |

## Verification
Every tower's result is due exactly 5 + d cycles after its peak sample is driven, where d is that channel's delay. A peak is only recognised once the following sample has arrived, yet that still falls inside those five cycles. The bench drives one sample on each falling edge and records `jet_et` on the same falling edge, before the new inputs change. It then compares every recorded cycle of a scenario with a reference built from R3 to R8. That reference places each tower's energy at index n + 5 + d. A result one cycle early or one cycle late therefore fails, and so does a stray non-zero value on any other crossing.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  // sample and energy widths
  localparam int unsigned TPP_SAMPLE_W = 10;
  localparam int unsigned TPP_ET_W     = 8;
  // towers per jet element, delay select width, sum width
  localparam int unsigned TPP_N_CH     = 4;
  localparam int unsigned TPP_DLY_W    = 3;
  localparam int unsigned TPP_SUM_W    = 10;
  // align reg + window reg + peak reg + table reg + sum reg
  localparam int unsigned TPP_BASE_LAT = 5;
endpackage

// File: rtl/tpp_align_delay.sv
module tpp_align_delay #(
  parameter int unsigned W     = 10,
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     samp_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [W-1:0]     samp_o
);
  localparam int unsigned TAPS = 1 << DLY_W;

  logic [W-1:0] hist_q [TAPS-1];
  logic [W-1:0] hist_d [TAPS-1];
  logic [W-1:0] tap    [TAPS];
  logic [W-1:0] out_d, out_q;

  // tap k is the input seen k clocks ago
  assign tap[0] = samp_i;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap[k] = hist_q[k-1];
  end

  always_comb begin
    hist_d[0] = samp_i;
    for (int k = 1; k < TAPS - 1; k++) begin
      hist_d[k] = hist_q[k-1];
    end
    out_d = tap[dly_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS - 1; k++) begin
        hist_q[k] <= '0;
      end
      out_q <= '0;
    end else begin
      for (int k = 0; k < TAPS - 1; k++) begin
        hist_q[k] <= hist_d[k];
      end
      out_q <= out_d;
    end
  end

  assign samp_o = out_q;
endmodule

// File: rtl/tpp_peak_find.sv
module tpp_peak_find #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp_i,
  input  logic [W-1:0] thr_i,
  output logic         hit_o,
  output logic [W-1:0] val_o
);
  logic [W-1:0] cur_q, prev_q, val_q;
  logic [W-1:0] cur_d, prev_d, val_d;
  logic         hit_q, hit_d, is_peak;

  // centre of the window is cur_q; samp_i is the crossing after it
  always_comb begin
    is_peak = (prev_q < cur_q) && (cur_q >= samp_i) && (cur_q > thr_i);
    cur_d   = samp_i;
    prev_d  = cur_q;
    hit_d   = is_peak;
    val_d   = is_peak ? cur_q : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      hit_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      hit_q  <= hit_d;
      val_q  <= val_d;
    end
  end

  assign hit_o = hit_q;
  assign val_o = val_q;

  // R3
  no_twin_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q);
endmodule

// File: rtl/tpp_energy_lut.sv
module tpp_energy_lut #(
  parameter int unsigned AW  = 10,
  parameter int unsigned DW  = 8,
  parameter int unsigned NRD = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [NRD-1:0]          rd_en_i,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage array: no reset, write strobe acts as clock enable
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] q, d;

    always_comb begin
      d = rd_en_i[p] ? mem[rd_addr_i[p]] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        q <= d;
      end
    end

    assign rd_data_o[p] = q;

    // R6
    quiet_off_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i[p] |=> (rd_data_o[p] == '0));
  end
endmodule

// File: rtl/tpp_tower_pre.sv
module tpp_tower_pre
  import tpp_pkg::*;
#(
  parameter int unsigned N_CH     = TPP_N_CH,
  parameter int unsigned SAMPLE_W = TPP_SAMPLE_W,
  parameter int unsigned ET_W     = TPP_ET_W,
  parameter int unsigned DLY_W    = TPP_DLY_W,
  parameter int unsigned SUM_W    = TPP_SUM_W,
  localparam int unsigned CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH*SAMPLE_W-1:0] samp_in,
  input  logic                     dly_wr,
  input  logic [CH_W-1:0]          dly_ch,
  input  logic [DLY_W-1:0]         dly_val,
  input  logic                     thr_wr,
  input  logic [SAMPLE_W-1:0]      thr_val,
  input  logic                     tbl_wr,
  input  logic [SAMPLE_W-1:0]      tbl_addr,
  input  logic [ET_W-1:0]          tbl_data,
  output logic [SUM_W-1:0]         jet_et
);
  localparam int unsigned ACC_W = ET_W + CH_W + 1;
  localparam logic [SUM_W-1:0] SUM_MAX = '1;
  localparam logic [ET_W-1:0]  ET_FULL = '1;

  // configuration registers
  logic [DLY_W-1:0]    dly_q [N_CH];
  logic [DLY_W-1:0]    dly_d [N_CH];
  logic [SAMPLE_W-1:0] thr_q, thr_d;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      dly_d[i] = (dly_wr && (dly_ch == CH_W'(i))) ? dly_val : dly_q[i];
    end
    thr_d = thr_wr ? thr_val : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        dly_q[i] <= '0;
      end
      thr_q <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        dly_q[i] <= dly_d[i];
      end
      thr_q <= thr_d;
    end
  end

  // per-tower alignment and crossing identification
  logic [N_CH-1:0]               hit;
  logic [N_CH-1:0][SAMPLE_W-1:0] pk_val;
  logic [N_CH-1:0][ET_W-1:0]     et;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] aligned;

    tpp_align_delay #(.W(SAMPLE_W), .DLY_W(DLY_W)) u_align (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp_i (samp_in[c*SAMPLE_W +: SAMPLE_W]),
      .dly_i  (dly_q[c]),
      .samp_o (aligned)
    );

    tpp_peak_find #(.W(SAMPLE_W)) u_peak (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp_i (aligned),
      .thr_i  (thr_q),
      .hit_o  (hit[c]),
      .val_o  (pk_val[c])
    );
  end

  tpp_energy_lut #(.AW(SAMPLE_W), .DW(ET_W), .NRD(N_CH)) u_lut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (tbl_wr),
    .wr_addr_i (tbl_addr),
    .wr_data_i (tbl_data),
    .rd_en_i   (hit),
    .rd_addr_i (pk_val),
    .rd_data_o (et)
  );

  // 2x2 summation with saturation
  logic [ACC_W-1:0] acc;
  logic             any_full, et_any;
  logic [SUM_W-1:0] sum_d, sum_q;

  always_comb begin
    acc      = '0;
    any_full = 1'b0;
    et_any   = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      acc      = acc + ACC_W'(et[i]);
      any_full = any_full | (et[i] == ET_FULL);
      et_any   = et_any | (|et[i]);
    end
    sum_d = (any_full || (acc > ACC_W'(SUM_MAX))) ? SUM_MAX : SUM_W'(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  assign jet_et = sum_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_sat_chk
    // R8
    full_scale_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (et[c] == ET_FULL) |=> (jet_et == SUM_MAX));
  end

  // R7
  sum_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jet_et != '0) |-> $past(et_any));
endmodule

// File: tb/tb_tpp_tower_pre.sv
module tb_tpp_tower_pre;
  import tpp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int L   = 24;
  localparam int RUN = 44;
  localparam int LAT = 5;

  logic        clk;
  logic        rst_n;
  logic [39:0] samp_in;
  logic        dly_wr;
  logic [1:0]  dly_ch;
  logic [2:0]  dly_val;
  logic        thr_wr;
  logic [9:0]  thr_val;
  logic        tbl_wr;
  logic [9:0]  tbl_addr;
  logic [7:0]  tbl_data;
  logic [9:0]  jet_et;

  int n_chk;
  int n_fail;
  int stim [NC][L];
  int dly_m [NC];
  int thr_m;
  int lut_m [1024];
  int got_a [RUN];

  tpp_tower_pre dut (
    .clk(clk), .rst_n(rst_n), .samp_in(samp_in),
    .dly_wr(dly_wr), .dly_ch(dly_ch), .dly_val(dly_val),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .jet_et(jet_et)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: energy of tower ch at aligned index n
  function automatic int tower_e(input int ch, input int n);
    int p, c, x;
    if (n < 0 || n >= L) return 0;
    p = (n > 0) ? stim[ch][n-1] : 0;
    c = stim[ch][n];
    x = (n < L - 1) ? stim[ch][n+1] : 0;
    if ((p < c) && (c >= x) && (c > thr_m)) return lut_m[c];
    return 0;
  endfunction

  function automatic int model_out(input int o);
    int s, e;
    bit full;
    s = 0;
    full = 1'b0;
    for (int ch = 0; ch < NC; ch++) begin
      e = tower_e(ch, o - LAT - dly_m[ch]);
      if (e == 255) full = 1'b1;
      s += e;
    end
    if (full || s > 1023) return 1023;
    return s;
  endfunction

  task automatic clear_stim();
    for (int ch = 0; ch < NC; ch++)
      for (int n = 0; n < L; n++) stim[ch][n] = 0;
  endtask

  task automatic set_delay(input int ch, input int v);
    @(negedge clk);
    dly_wr = 1'b1; dly_ch = 2'(ch); dly_val = 3'(v);
    @(negedge clk);
    dly_wr = 1'b0;
    dly_m[ch] = v;
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_wr = 1'b1; thr_val = 10'(v);
    @(negedge clk);
    thr_wr = 1'b0;
    thr_m = v;
  endtask

  task automatic tbl_write(input int a, input int d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_addr = 10'(a); tbl_data = 8'(d);
    @(negedge clk);
    tbl_wr = 1'b0;
    lut_m[a] = d;
  endtask

  // stream the stimulus and compare every cycle against the model
  task automatic run_cmp(input string tag);
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      got_a[c] = int'(jet_et);
      for (int ch = 0; ch < NC; ch++)
        samp_in[ch*10 +: 10] = (c < L) ? 10'(stim[ch][c]) : 10'd0;
    end
    for (int o = 0; o < RUN; o++) chk(tag, got_a[o], model_out(o));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sum during reset", int'(jet_et), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sum after reset", int'(jet_et), 0);
  endtask

  task automatic t_program_table();
    @(negedge clk);
    for (int a = 0; a < 1024; a++) begin
      tbl_wr = 1'b1; tbl_addr = 10'(a); tbl_data = 8'(a >> 2);
      lut_m[a] = a >> 2;
      @(negedge clk);
    end
    tbl_wr = 1'b0;
    chk("R6 idle while programming", int'(jet_et), 0);
  endtask

  task automatic t_basic();
    clear_stim();
    stim[0][1] = 10; stim[0][2] = 50; stim[0][3] = 200;
    stim[0][4] = 120; stim[0][5] = 30;
    run_cmp("R1 R3 R5 R9 basic pulse, reset delays");
    chk("R9 peak at n+5", got_a[3+LAT], 50);
    chk("R6 zero one cycle early", got_a[3+LAT-1], 0);
    chk("R6 zero one cycle late", got_a[3+LAT+1], 0);
    chk("R9 base latency constant", int'(TPP_BASE_LAT), 5);
  endtask

  task automatic t_sum();
    clear_stim();
    stim[0][3] = 200; stim[0][4] = 400; stim[0][5] = 200;
    stim[1][3] = 100; stim[1][4] = 200; stim[1][5] = 100;
    stim[2][3] = 50;  stim[2][4] = 100; stim[2][5] = 50;
    stim[3][3] = 20;  stim[3][4] = 40;  stim[3][5] = 20;
    run_cmp("R7 four tower sum");
    chk("R7 sum 100+50+25+10", got_a[4+LAT], 185);
  endtask

  task automatic t_plateau();
    clear_stim();
    stim[0][2] = 80; stim[0][3] = 80;
    stim[1][6] = 30; stim[1][7] = 60; stim[1][8] = 90;
    stim[1][9] = 90; stim[1][10] = 90; stim[1][11] = 10;
    run_cmp("R3 plateau");
    chk("R3 first of plateau", got_a[2+LAT], 20);
    chk("R3 second of plateau silent", got_a[3+LAT], 0);
    chk("R3 long plateau first", got_a[8+LAT], 22);
    chk("R3 long plateau later silent", got_a[9+LAT], 0);
  endtask

  task automatic t_threshold();
    set_thr(100);
    clear_stim();
    stim[0][2] = 50;  stim[0][3] = 100; stim[0][4] = 50;
    stim[1][9] = 50;  stim[1][10] = 101; stim[1][11] = 50;
    run_cmp("R4 threshold");
    chk("R4 equal to threshold rejected", got_a[3+LAT], 0);
    chk("R4 above threshold accepted", got_a[10+LAT], 25);
    set_thr(0);
  endtask

  task automatic t_delay();
    set_delay(1, 3);
    set_delay(2, 5);
    set_delay(3, 7);
    clear_stim();
    for (int ch = 0; ch < NC; ch++) begin
      stim[ch][1] = 200; stim[ch][2] = 400; stim[ch][3] = 100;
    end
    run_cmp("R2 per-channel delays");
    chk("R2 delay 0", got_a[2+LAT], 100);
    chk("R2 delay 3", got_a[2+LAT+3], 100);
    chk("R2 delay 5", got_a[2+LAT+5], 100);
    chk("R2 delay 7", got_a[2+LAT+7], 100);
    chk("R2 gap between delays", got_a[2+LAT+4], 0);
    for (int ch = 1; ch < NC; ch++) set_delay(ch, 0);
  endtask

  task automatic t_saturate();
    clear_stim();
    stim[0][2] = 500; stim[0][3] = 1023; stim[0][4] = 10;
    stim[1][2] = 20;  stim[1][3] = 40;   stim[1][4] = 20;
    for (int ch = 0; ch < NC; ch++) begin
      stim[ch][10] = 500; stim[ch][11] = 1016; stim[ch][12] = 10;
    end
    run_cmp("R8 saturation");
    chk("R8 full-scale tower saturates", got_a[3+LAT], 1023);
    chk("R8 four times 0xFE unclamped", got_a[11+LAT], 1016);
  endtask

  task automatic t_table();
    tbl_write(300, 17);
    clear_stim();
    stim[2][4] = 150; stim[2][5] = 300; stim[2][6] = 150;
    run_cmp("R5 rewritten entry");
    chk("R5 new table value", got_a[5+LAT], 17);
    tbl_write(300, 75);
  endtask

  task automatic t_multi();
    clear_stim();
    stim[0][1] = 50; stim[0][2] = 40; stim[0][3] = 60;
    stim[0][8] = 10; stim[0][9] = 20; stim[0][10] = 30; stim[0][11] = 40;
    run_cmp("R3 R6 double peak and ramp");
    chk("R3 first peak", got_a[1+LAT], 12);
    chk("R6 dip is silent", got_a[2+LAT], 0);
    chk("R3 second peak", got_a[3+LAT], 15);
    chk("R6 rising ramp silent", got_a[10+LAT], 0);
    chk("R3 ramp top", got_a[11+LAT], 10);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; thr_m = 0;
    for (int ch = 0; ch < NC; ch++) dly_m[ch] = 0;
    samp_in = '0; dly_wr = 1'b0; dly_ch = '0; dly_val = '0;
    thr_wr = 1'b0; thr_val = '0; tbl_wr = 1'b0; tbl_addr = '0; tbl_data = '0;
    t_reset();
    t_program_table();
    t_basic();
    t_sum();
    t_plateau();
    t_threshold();
    t_delay();
    t_saturate();
    t_table();
    t_multi();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule